// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is a direct-mapped cache that sits between one pipeline port and a synchronous backing memory. It can serve either as the instruction cache or as the data cache, with one instance for each role so that fetch and load/store traffic never contend. The pipeline side offers a single word request with an address, a write flag, a byte mask and write data. The cache answers with a response strobe and read data, and it holds a stall signal while it is busy. The memory side moves whole lines: it issues line read and line write requests under a ready handshake and takes refill data under a valid strobe.

Each line has a valid bit, a dirty bit and a tag. Stores that hit are merged into the line under the byte mask and mark it dirty. Misses evict a dirty victim to memory before the refill. Store misses allocate the line first and then perform the write. A six-state controller walks through idle, tag check, store write, write-back, refill request and refill response. Because the line array is read after the request is registered, even a hit answers on the cycle after the request is accepted.

Top module: `wbc_cache`

## Requirements
- R1: After reset every line is invalid and not dirty, `cpu_stall`, `cpu_resp_valid` and `mem_req_valid` are low, and the first access to any address is a miss.
- R2: A read hit raises `cpu_resp_valid` with the addressed word on `cpu_resp_rdata` in the cycle after the request is accepted, and it issues no memory request.
- R3: A request is accepted on a rising edge where `cpu_req_valid` is high and `cpu_stall` is low. `cpu_stall` is high from the cycle after acceptance up to and including the response cycle, and it is low in the cycle after the response.
- R4: A miss on an invalid or clean line issues exactly one line read at the line-aligned address and no line write. After the refill it returns the word from the refilled line, and the line is then clean.
- R5: A miss on a valid dirty line first issues a line write carrying the victim's full contents at the victim's line-aligned address (old tag, same index). The line read for the new address follows immediately after the write is accepted.
- R6: A store hit replaces only the bytes whose `cpu_req_mask` bit is set, with mask bit b selecting bits 8b+7..8b of the word. It raises `cpu_resp_valid` two cycles after acceptance, makes no memory request, and marks the line dirty, so its later eviction writes the line back.
- R7: A store miss is write-allocate: the line is refilled as in R4 or R5, and the masked store is then merged into it and leaves it dirty.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` does not change.
- R9: Address fields: bits 31..10 are the tag, bits 9..4 select one of 64 lines, bits 3..2 select the word within the 16-byte line, and bits 1..0 are ignored.
- R10: On both memory data buses, word k of a line (byte address offset 4k) occupies bits 32k+31..32k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_req_valid | input | 1 | Pipeline request present |
| cpu_req_addr | input | 32 | Byte address of the access |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_mask | input | 4 | Byte lanes written by a store |
| cpu_req_wdata | input | 32 | Store data |
| cpu_stall | output | 1 | Cache busy; no request accepted |
| cpu_resp_valid | output | 1 | Access completes this cycle |
| cpu_resp_rdata | output | 32 | Load data, valid with a load response |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_we | output | 1 | 1 = line write (eviction), 0 = line read |
| mem_req_addr | output | 32 | Line-aligned memory address |
| mem_req_wdata | output | 128 | Victim line for a write |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_resp_valid | input | 1 | Refill data present |
| mem_resp_data | input | 128 | Refill line |

## Verification
A corrupted tag or valid bit shows at the ports on the very next access to that index. It appears as memory traffic where a hit was due, as a hit without traffic where a miss was due, or as wrong load data in the response cycle. A lost dirty bit stays hidden until the line is evicted. The bench compares every write-back against a flat reference image of memory and rereads evicted words from the backing store, so a missing or stale eviction surfaces as a data mismatch on a later load. The bench also keeps its own shadow of tags, valid bits and dirty bits to predict hit, clean miss or dirty miss for each access, and it checks response latency and traffic counts against that prediction.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_TAG_CHECK  = 3'd1,
    ST_WRITE      = 3'd2,
    ST_WRITE_BACK = 3'd3,
    ST_MEM_FETCH  = 3'd4,
    ST_MEM_RESP   = 3'd5
  } wbc_state_e;

endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int NUM_LINES = 64,
  parameter int TAG_W     = 22,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_dirty,
  output logic             line_valid,
  output logic             line_dirty,
  output logic [TAG_W-1:0] line_tag
);

  logic [NUM_LINES-1:0] valid_q;
  logic [NUM_LINES-1:0] dirty_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q <= '0;
    end else if (fill_en) begin
      dirty_q[idx] <= 1'b0;
    end else if (mark_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[idx] <= fill_tag;
    end
  end

  assign line_valid = valid_q[idx];
  assign line_dirty = dirty_q[idx];
  assign line_tag   = tag_q[idx];

  AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ((dirty_q & ~valid_q) == '0)); // R6

  AST_FILL_LEAVES_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (valid_q[$past(idx)] && !dirty_q[$past(idx)])); // R4

  AST_STORE_SETS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_dirty && !fill_en) |=> dirty_q[$past(idx)]); // R6

endmodule

// File: rtl/wbc_line_store.sv
module wbc_line_store #(
  parameter int NUM_LINES  = 64,
  parameter int LINE_BYTES = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int WORD_W    = WORD_BYTES * 8,
  localparam int WSEL_W    = $clog2(LINE_BYTES / WORD_BYTES)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              st_en,
  input  logic [WSEL_W-1:0] st_word,
  input  logic [WORD_BYTES-1:0] st_mask,
  input  logic [WORD_W-1:0] st_wdata,
  output logic [LINE_W-1:0] rd_line
);

  logic [LINE_W-1:0]     line_q [NUM_LINES];
  logic [LINE_W-1:0]     next_line;
  logic [LINE_BYTES-1:0] byte_we;

  assign rd_line = line_q[idx];

  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
    assign byte_we[g] = st_en && (st_word == WSEL_W'(g / WORD_BYTES))
                        && st_mask[g % WORD_BYTES];
    assign next_line[g*8 +: 8] = fill_en    ? fill_line[g*8 +: 8] :
                                 byte_we[g] ? st_wdata[(g % WORD_BYTES)*8 +: 8] :
                                              rd_line[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (fill_en || st_en) begin
      line_q[idx] <= next_line;
    end
  end

  AST_FILL_STORE_EXCL: assert property (@(posedge clk)
    !(fill_en && st_en)); // R7

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req_valid,
  input  logic req_we,
  input  logic hit,
  input  logic victim_dirty,
  input  logic mem_req_ready,
  input  logic mem_resp_valid,
  output logic accept,
  output logic fill_en,
  output logic st_en,
  output logic cpu_stall,
  output logic cpu_resp_valid,
  output logic mem_req_valid,
  output logic mem_req_we
);

  wbc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (cpu_req_valid) state_d = ST_TAG_CHECK;
      ST_TAG_CHECK: begin
        if (hit)               state_d = req_we ? ST_WRITE : ST_IDLE;
        else if (victim_dirty) state_d = ST_WRITE_BACK;
        else                   state_d = ST_MEM_FETCH;
      end
      ST_WRITE:      state_d = ST_IDLE;
      ST_WRITE_BACK: if (mem_req_ready)  state_d = ST_MEM_FETCH;
      ST_MEM_FETCH:  if (mem_req_ready)  state_d = ST_MEM_RESP;
      ST_MEM_RESP:   if (mem_resp_valid) state_d = ST_TAG_CHECK;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign accept         = (state_q == ST_IDLE) && cpu_req_valid;
  assign fill_en        = (state_q == ST_MEM_RESP) && mem_resp_valid;
  assign st_en          = (state_q == ST_WRITE);
  assign cpu_stall      = (state_q != ST_IDLE);
  assign cpu_resp_valid = ((state_q == ST_TAG_CHECK) && hit && !req_we) || (state_q == ST_WRITE);
  assign mem_req_valid  = (state_q == ST_WRITE_BACK) || (state_q == ST_MEM_FETCH);
  assign mem_req_we     = (state_q == ST_WRITE_BACK);

  AST_ACCEPT_THEN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cpu_stall); // R3

  AST_RESP_FREES_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp_valid |=> !cpu_stall); // R3

  AST_WB_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we && mem_req_ready) |=> (mem_req_valid && !mem_req_we)); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid); // R8

  AST_RESP_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp_valid |-> !mem_req_valid); // R2

endmodule

// File: rtl/wbc_cache.sv
module wbc_cache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 64,
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int LINE_W     = LINE_BYTES * 8,
  localparam int WORD_OFF   = $clog2(WORD_BYTES),
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int IDX_W      = $clog2(NUM_LINES),
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W,
  localparam int WSEL_W     = OFF_W - WORD_OFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_req_valid,
  input  logic [ADDR_W-1:0]     cpu_req_addr,
  input  logic                  cpu_req_we,
  input  logic [WORD_BYTES-1:0] cpu_req_mask,
  input  logic [WORD_W-1:0]     cpu_req_wdata,
  output logic                  cpu_stall,
  output logic                  cpu_resp_valid,
  output logic [WORD_W-1:0]     cpu_resp_rdata,
  output logic                  mem_req_valid,
  output logic                  mem_req_we,
  output logic [ADDR_W-1:0]     mem_req_addr,
  output logic [LINE_W-1:0]     mem_req_wdata,
  input  logic                  mem_req_ready,
  input  logic                  mem_resp_valid,
  input  logic [LINE_W-1:0]     mem_resp_data
);

  logic [TAG_W-1:0]      tag_q;
  logic [IDX_W-1:0]      idx_q;
  logic [WSEL_W-1:0]     word_q;
  logic                  we_q;
  logic [WORD_BYTES-1:0] mask_q;
  logic [WORD_W-1:0]     wdata_q;

  logic              accept, fill_en, st_en;
  logic              line_valid, line_dirty;
  logic [TAG_W-1:0]  line_tag;
  logic [LINE_W-1:0] rd_line;
  logic              hit, victim_dirty;

  // request capture, clock-enabled on acceptance
  always_ff @(posedge clk) begin
    if (accept) begin
      tag_q   <= cpu_req_addr[ADDR_W-1 -: TAG_W];
      idx_q   <= cpu_req_addr[OFF_W +: IDX_W];
      word_q  <= cpu_req_addr[WORD_OFF +: WSEL_W];
      we_q    <= cpu_req_we;
      mask_q  <= cpu_req_mask;
      wdata_q <= cpu_req_wdata;
    end
  end

  assign hit          = line_valid && (line_tag == tag_q);
  assign victim_dirty = line_valid && line_dirty;

  wbc_ctrl i_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_valid  (cpu_req_valid),
    .req_we         (we_q),
    .hit            (hit),
    .victim_dirty   (victim_dirty),
    .mem_req_ready  (mem_req_ready),
    .mem_resp_valid (mem_resp_valid),
    .accept         (accept),
    .fill_en        (fill_en),
    .st_en          (st_en),
    .cpu_stall      (cpu_stall),
    .cpu_resp_valid (cpu_resp_valid),
    .mem_req_valid  (mem_req_valid),
    .mem_req_we     (mem_req_we)
  );

  wbc_tag_store #(
    .NUM_LINES (NUM_LINES),
    .TAG_W     (TAG_W)
  ) i_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (idx_q),
    .fill_en    (fill_en),
    .fill_tag   (tag_q),
    .mark_dirty (st_en),
    .line_valid (line_valid),
    .line_dirty (line_dirty),
    .line_tag   (line_tag)
  );

  wbc_line_store #(
    .NUM_LINES  (NUM_LINES),
    .LINE_BYTES (LINE_BYTES),
    .WORD_BYTES (WORD_BYTES)
  ) i_lines (
    .clk       (clk),
    .idx       (idx_q),
    .fill_en   (fill_en),
    .fill_line (mem_resp_data),
    .st_en     (st_en),
    .st_word   (word_q),
    .st_mask   (mask_q),
    .st_wdata  (wdata_q),
    .rd_line   (rd_line)
  );

  assign cpu_resp_rdata = rd_line[word_q*WORD_W +: WORD_W];
  assign mem_req_wdata  = rd_line;
  assign mem_req_addr   = {(mem_req_we ? line_tag : tag_q), idx_q, {OFF_W{1'b0}}};

  AST_REQ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr)); // R8

  AST_HIT_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_resp_valid && !we_q) |-> (line_valid && line_tag == tag_q)); // R2

endmodule

// File: tb/test_wbc_cache.sv
module test_wbc_cache;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 4096;

  logic         clk;
  logic         rst_n;
  logic         cpu_req_valid;
  logic [31:0]  cpu_req_addr;
  logic         cpu_req_we;
  logic [3:0]   cpu_req_mask;
  logic [31:0]  cpu_req_wdata;
  logic         cpu_stall;
  logic         cpu_resp_valid;
  logic [31:0]  cpu_resp_rdata;
  logic         mem_req_valid;
  logic         mem_req_we;
  logic [31:0]  mem_req_addr;
  logic [127:0] mem_req_wdata;
  logic         mem_req_ready;
  logic         mem_resp_valid;
  logic [127:0] mem_resp_data;

  wbc_cache i_wbc_cache (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_addr   (cpu_req_addr),
    .cpu_req_we     (cpu_req_we),
    .cpu_req_mask   (cpu_req_mask),
    .cpu_req_wdata  (cpu_req_wdata),
    .cpu_stall      (cpu_stall),
    .cpu_resp_valid (cpu_resp_valid),
    .cpu_resp_rdata (cpu_resp_rdata),
    .mem_req_valid  (mem_req_valid),
    .mem_req_we     (mem_req_we),
    .mem_req_addr   (mem_req_addr),
    .mem_req_wdata  (mem_req_wdata),
    .mem_req_ready  (mem_req_ready),
    .mem_resp_valid (mem_resp_valid),
    .mem_resp_data  (mem_resp_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] bmem    [MEM_WORDS];  // backing store seen by the cache
  logic [31:0] ref_mem [MEM_WORDS];  // flat architectural image
  bit          sh_v [64];
  bit          sh_d [64];
  logic [21:0] sh_t [64];

  int          wb_cnt = 0;
  int          rd_cnt = 0;
  logic [31:0] wb_addr;
  logic [127:0] wb_data;

  function automatic logic [31:0] pattern(int i);
    return (i * 32'h9E37_79B1) ^ 32'hA5A5_0000;
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] m);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (m[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [127:0] ref_line(logic [31:0] a);
    logic [127:0] l;
    int base = int'(a[13:4]) * 4;
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = ref_mem[base + k];
    return l;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // backing memory responder, all driving at the falling edge
  initial begin
    int wait_cnt = 0;
    int resp_cnt = 0;
    bit rd_pend  = 0;
    logic [31:0] rd_a = '0;
    mem_req_ready  = 1'b0;
    mem_resp_valid = 1'b0;
    mem_resp_data  = '0;
    forever begin
      @(negedge clk);
      mem_req_ready  = 1'b0;
      mem_resp_valid = 1'b0;
      if (rd_pend) begin
        if (resp_cnt == 0) begin
          for (int k = 0; k < 4; k++)
            mem_resp_data[k*32 +: 32] = bmem[int'(rd_a[13:4]) * 4 + k];
          mem_resp_valid = 1'b1;
          rd_pend = 0;
        end else resp_cnt--;
      end else if (mem_req_valid) begin
        if (wait_cnt == 0) begin
          mem_req_ready = 1'b1;
          wait_cnt = int'($urandom % 3);
          if (mem_req_we) begin
            wb_cnt++;
            wb_addr = mem_req_addr;
            wb_data = mem_req_wdata;
            for (int k = 0; k < 4; k++)
              bmem[int'(mem_req_addr[13:4]) * 4 + k] = mem_req_wdata[k*32 +: 32];
          end else begin
            rd_cnt++;
            rd_pend  = 1;
            rd_a     = mem_req_addr;
            resp_cnt = int'($urandom % 3);
          end
        end else wait_cnt--;
      end
    end
  end

  task automatic access(logic [31:0] a, bit we, logic [3:0] m, logic [31:0] wd);
    int idx = int'(a[9:4]);
    logic [21:0] tg = a[31:10];
    bit hit = sh_v[idx] && sh_t[idx] == tg;
    bit exp_wb = !hit && sh_v[idx] && sh_d[idx];
    logic [31:0] vict = {sh_t[idx], a[9:4], 4'h0};
    logic [127:0] vict_line = ref_line(vict);
    int wb0 = wb_cnt;
    int rd0 = rd_cnt;
    int cyc;
    int w = int'(a[13:2]);
    @(negedge clk);
    chk(cpu_stall == 1'b0, "R3 idle before request", 128'(cpu_stall), 128'd0);
    cpu_req_valid = 1'b1; cpu_req_addr = a; cpu_req_we = we;
    cpu_req_mask = m; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    cyc = 1;
    while (!cpu_resp_valid && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    chk(cpu_resp_valid && cpu_stall, "R3 stall held through response",
        128'({cpu_resp_valid, cpu_stall}), 128'b11);
    if (hit && !we) chk(cyc == 1, "R2 read hit latency", 128'(cyc), 128'd1);
    if (hit && we)  chk(cyc == 2, "R6 store hit latency", 128'(cyc), 128'd2);
    if (!we) chk(cpu_resp_rdata == ref_mem[w], "R4 R9 load data",
                 128'(cpu_resp_rdata), 128'(ref_mem[w]));
    chk(rd_cnt - rd0 == (hit ? 0 : 1), hit ? "R2 no refill on hit" : "R4 one refill on miss",
        128'(rd_cnt - rd0), 128'(hit ? 0 : 1));
    chk(wb_cnt - wb0 == (exp_wb ? 1 : 0), exp_wb ? "R5 dirty victim written" : "R4 no write-back",
        128'(wb_cnt - wb0), 128'(exp_wb ? 1 : 0));
    if (exp_wb) begin
      chk(wb_addr == vict, "R5 write-back address", 128'(wb_addr), 128'(vict));
      chk(wb_data == vict_line, "R10 write-back line", wb_data, vict_line);
    end
    if (!hit) begin sh_v[idx] = 1; sh_t[idx] = tg; sh_d[idx] = 0; end
    if (we) begin
      ref_mem[w] = merge(ref_mem[w], wd, m);
      sh_d[idx] = 1;  // R7 write-allocate leaves line dirty
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEM_WORDS; i++) begin
      bmem[i] = pattern(i); ref_mem[i] = pattern(i);
    end
    for (int i = 0; i < 64; i++) begin sh_v[i] = 0; sh_d[i] = 0; sh_t[i] = '0; end
    rst_n = 1'b0; cpu_req_valid = 1'b0; cpu_req_addr = '0; cpu_req_we = 1'b0;
    cpu_req_mask = '0; cpu_req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({cpu_stall, cpu_resp_valid, mem_req_valid} == 3'b000, "R1 outputs after reset",
        128'({cpu_stall, cpu_resp_valid, mem_req_valid}), 128'd0);

    // R1 R4 cold miss, then R2 hit, R9 word select with low bits ignored
    access(32'h0000_040E, 0, 4'h0, '0);
    access(32'h0000_0404, 0, 4'h0, '0);
    // R6 store hit with partial mask, then read back merged word
    access(32'h0000_0408, 1, 4'b0101, 32'hDEAD_BEEF);
    access(32'h0000_0408, 0, 4'h0, '0);
    // R5 dirty eviction by same index, other tag; then reread evicted word
    access(32'h0000_0808, 0, 4'h0, '0);
    access(32'h0000_0408, 0, 4'h0, '0);
    // R7 store miss allocates, then R5 its eviction writes the merged line
    access(32'h0000_0C30, 1, 4'b1000, 32'h7700_0000);
    access(32'h0000_0C30, 0, 4'h0, '0);
    access(32'h0000_1030, 0, 4'h0, '0);
    access(32'h0000_0C30, 0, 4'h0, '0);
    // R4 clean victim replaced without write-back
    access(32'h0000_1430, 0, 4'h0, '0);

    // random mix over few indices and tags to force hits and evictions
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a = {18'd0, 4'($urandom % 8), 6'($urandom % 6), 2'($urandom % 4), 2'b00};
      bit st = ($urandom % 3) == 0;
      access(a, st, 4'($urandom), $urandom);
    end
    // final sweep: every word of the region read through the cache
    for (int i = 0; i < 8 * 6 * 4; i++) begin
      access({18'd0, 4'(i / 24), 6'((i / 4) % 6), 2'(i % 4), 2'b00}, 0, 4'h0, '0);
    end

    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule